// File: doc/BRIEF.md
# Bridge Window Register Bank

This block is the configuration register bank of a host-to-PCI bridge. It holds the registers that a downstream address translator needs: four window base registers, four window mask registers, four translated-base registers and one control register, each 64 bits wide. A host reaches them through a simple request/response slave port. Every register sits in its own 64-byte slot above a base address set by a parameter. All thirteen stored values are driven out in parallel as registered outputs, so the translator can read them directly.

Only full 8-byte accesses are legal. The slave port also answers for a set of bridge functions that this bank does not provide: platform, reserved, error status, error mask, error set, invalidate-one-entry, monitor control and monitor count. Accesses to these, and to any index outside the map, return an error. One write-only "invalidate everything" slot reads back zero and quietly accepts writes.

The port logic is a two-state machine. In state ST_IDLE it raises `req_ready`. The transition ACCEPT (`req_valid` seen in ST_IDLE) commits any write and captures the response, and the machine moves to ST_RESP. In ST_RESP it shows `rsp_valid` for one cycle with `req_ready` low, then takes the transition DONE back to ST_IDLE without condition.

Top module: `bwin_bank`

## Requirements
- R1: `req_ready` is high in ST_IDLE and low in ST_RESP. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `rsp_valid` is high for exactly the one cycle that follows each acceptance and is low at every other time.
- R2: The slot index is (`req_addr` - BASE) >> 6, so address bits 5:0 are ignored. Index map: 0..3 are window base 0..3, 4..7 are window mask 0..3, 8..11 are translated base 0..3, 12 is control, and 19 is invalidate-all. An address below BASE is an error.
- R3: `req_size` holds log2 of the byte count (0=1, 1=2, 2=4, 3=8 bytes). Any size other than 3 gives `rsp_err`=1.
- R4: After reset, all twelve window registers read zero and the control register reads 64'h0000_0021_0010_0000 (bits 20, 32 and 37 set).
- R5: A legal write stores `req_wdata` in the addressed register. A later legal read of that register returns the stored value with `rsp_err`=0.
- R6: A read of index 19 returns zero with no error. A write to index 19 completes with no error and changes no register.
- R7: Indices 13 to 18, 20, 21 and every index above 21 give `rsp_err`=1.
- R8: An access that errors changes no register, and its `rsp_rdata` is zero.
- R9: A read changes no register. The response to a legal write carries `rsp_rdata`=0.
- R10: `win_base_o`, `win_mask_o`, `xlat_base_o` and `ctrl_o` show the register contents (slot k in bits 64k+63:64k). A write becomes visible on them in the same cycle that its `rsp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can accept a request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | log2 of access size in bytes |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Read data |
| rsp_err | output | 1 | Access error |
| win_base_o | output | NWIN*64 | Window base registers |
| win_mask_o | output | NWIN*64 | Window mask registers |
| xlat_base_o | output | NWIN*64 | Translated-base registers |
| ctrl_o | output | 64 | Control register |

## Verification
On every cycle the assertions check the handshake shape. They also check that an erroring access, or any read, leaves all four register outputs unchanged, that a bad size always errors, and that error responses carry zero data. Only the bench's scenarios can show that the decode lands each address on the right slot and that the reset constants are correct. The same holds for write-then-read round trips, and for the invalidate slot reading zero while absorbing writes. The bench checks these against a reference model of the register map, using random accesses and directed corner cases.

// File: rtl/bwin_pkg.sv
package bwin_pkg;
    localparam int DATA_W = 64;
    localparam int NWIN   = 4;
    localparam int SLOT_W = $clog2(NWIN);

    localparam int IDX_WBASE = 0;
    localparam int IDX_WMASK = IDX_WBASE + NWIN;
    localparam int IDX_XBASE = IDX_WMASK + NWIN;
    localparam int IDX_CTRL  = IDX_XBASE + NWIN;
    localparam int IDX_INVAL = 19;

    localparam logic [DATA_W-1:0] CTRL_RST = 64'h0000_0021_0010_0000;

    typedef enum logic [2:0] {
        TGT_WBASE,
        TGT_WMASK,
        TGT_XBASE,
        TGT_CTRL,
        TGT_INVAL,
        TGT_BAD
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [SLOT_W-1:0] slot;
    } dec_t;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } state_e;
endpackage

// File: rtl/bwin_decode.sv
module bwin_decode
    import bwin_pkg::*;
#(
    parameter int               ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE  = 32'h0001_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int SLOT_SHIFT = 6;

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] idx;
    logic              below;

    always_comb begin
        below  = addr < BASE;
        offset = addr - BASE;
        idx    = offset >> SLOT_SHIFT;
        dec.slot = idx[SLOT_W-1:0];
        dec.tgt  = TGT_BAD;
        if (!below) begin
            if (idx < ADDR_W'(IDX_WMASK))
                dec.tgt = TGT_WBASE;
            else if (idx < ADDR_W'(IDX_XBASE))
                dec.tgt = TGT_WMASK;
            else if (idx < ADDR_W'(IDX_CTRL))
                dec.tgt = TGT_XBASE;
            else if (idx == ADDR_W'(IDX_CTRL))
                dec.tgt = TGT_CTRL;
            else if (idx == ADDR_W'(IDX_INVAL))
                dec.tgt = TGT_INVAL;
        end
    end
endmodule

// File: rtl/bwin_store.sv
module bwin_store
    import bwin_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  dec_t                        dec,
    input  logic [DATA_W-1:0]           wdata,
    output logic [NWIN-1:0][DATA_W-1:0] wbase_q,
    output logic [NWIN-1:0][DATA_W-1:0] wmask_q,
    output logic [NWIN-1:0][DATA_W-1:0] xbase_q,
    output logic [DATA_W-1:0]           ctrl_q,
    output logic [DATA_W-1:0]           rd_data
);
    for (genvar g = 0; g < NWIN; g++) begin : g_win
        logic hit;
        assign hit = wr_en && (dec.slot == SLOT_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wbase_q[g] <= '0;
                wmask_q[g] <= '0;
                xbase_q[g] <= '0;
            end else if (hit) begin
                if (dec.tgt == TGT_WBASE) wbase_q[g] <= wdata;
                if (dec.tgt == TGT_WMASK) wmask_q[g] <= wdata;
                if (dec.tgt == TGT_XBASE) xbase_q[g] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_RST;
        else if (wr_en && dec.tgt == TGT_CTRL)
            ctrl_q <= wdata;
    end

    always_comb begin
        unique case (dec.tgt)
            TGT_WBASE: rd_data = wbase_q[dec.slot];
            TGT_WMASK: rd_data = wmask_q[dec.slot];
            TGT_XBASE: rd_data = xbase_q[dec.slot];
            TGT_CTRL:  rd_data = ctrl_q;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/bwin_fsm.sv
module bwin_fsm
    import bwin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic req_ready,
    output logic accept,
    output logic rsp_valid
);
    state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        accept    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                accept    = req_valid;
                if (req_valid) state_d = ST_RESP;
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/bwin_bank.sv
module bwin_bank
    import bwin_pkg::*;
#(
    parameter int                ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE   = 32'h0001_0000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_write,
    input  logic [1:0]               req_size,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic                     rsp_err,
    output logic [NWIN*DATA_W-1:0]   win_base_o,
    output logic [NWIN*DATA_W-1:0]   win_mask_o,
    output logic [NWIN*DATA_W-1:0]   xlat_base_o,
    output logic [DATA_W-1:0]        ctrl_o
);
    localparam logic [1:0] SIZE_FULL = 2'd3;

    dec_t                        dec;
    logic                        accept;
    logic                        bad;
    logic                        wr_en;
    logic [DATA_W-1:0]           rd_data;
    logic [NWIN-1:0][DATA_W-1:0] wbase_q, wmask_q, xbase_q;
    logic [DATA_W-1:0]           ctrl_q;

    bwin_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .addr (req_addr),
        .dec  (dec)
    );

    bwin_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .accept    (accept),
        .rsp_valid (rsp_valid)
    );

    assign bad   = (dec.tgt == TGT_BAD) || (req_size != SIZE_FULL);
    assign wr_en = accept && req_write && !bad;

    bwin_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .dec     (dec),
        .wdata   (req_wdata),
        .wbase_q (wbase_q),
        .wmask_q (wmask_q),
        .xbase_q (xbase_q),
        .ctrl_q  (ctrl_q),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else if (accept) begin
            rsp_err   <= bad;
            rsp_rdata <= (bad || req_write) ? '0 : rd_data;
        end
    end

    assign win_base_o  = wbase_q;
    assign win_mask_o  = wmask_q;
    assign xlat_base_o = xbase_q;
    assign ctrl_o      = ctrl_q;
endmodule

// File: rtl/bwin_chk.sv
module bwin_chk
    import bwin_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic                   req_write,
    input logic [1:0]             req_size,
    input logic                   rsp_valid,
    input logic [DATA_W-1:0]      rsp_rdata,
    input logic                   rsp_err,
    input logic [NWIN*DATA_W-1:0] win_base_o,
    input logic [NWIN*DATA_W-1:0] win_mask_o,
    input logic [NWIN*DATA_W-1:0] xlat_base_o,
    input logic [DATA_W-1:0]      ctrl_o
);
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R1
    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid); // R1
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid); // R1
    AST_SHORT_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_size) != 2'd3) |-> rsp_err); // R3
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> rsp_rdata == '0); // R8
    AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> ($stable(win_base_o) && $stable(win_mask_o)
                                    && $stable(xlat_base_o) && $stable(ctrl_o))); // R8
    AST_READ_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(req_write)) |-> ($stable(win_base_o) && $stable(win_mask_o)
                                    && $stable(xlat_base_o) && $stable(ctrl_o))); // R9
endmodule

bind bwin_bank bwin_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_size    (req_size),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .rsp_err     (rsp_err),
    .win_base_o  (win_base_o),
    .win_mask_o  (win_mask_o),
    .xlat_base_o (xlat_base_o),
    .ctrl_o      (ctrl_o)
);

// File: tb/bwin_bank_tb.sv
module bwin_bank_tb_top;
    localparam int          ADDR_W = 32;
    localparam logic [31:0] BASE   = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd3;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rsp_err;
    logic [255:0] win_base_o, win_mask_o, xlat_base_o;
    logic [63:0] ctrl_o;

    int n_chk = 0;
    int n_bad = 0;
    longint cycles = 0;

    logic [63:0] m_wb [4];
    logic [63:0] m_wm [4];
    logic [63:0] m_xb [4];
    logic [63:0] m_ctrl;

    always #2 clk = ~clk;

    bwin_bank #(.ADDR_W(ADDR_W), .BASE(BASE)) dut_i (.*);

    task automatic check(string req, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int idx_of(logic [31:0] a);
        if (a < BASE) return -1;
        return int'((a - BASE) >> 6);
    endfunction

    function automatic bit is_err(logic [31:0] a, logic [1:0] sz);
        int i = idx_of(a);
        if (sz != 2'd3) return 1;
        if (i < 0) return 1;
        return !(i <= 12 || i == 19);
    endfunction

    function automatic logic [63:0] model_read(int i);
        if (i < 4)        return m_wb[i];
        else if (i < 8)   return m_wm[i-4];
        else if (i < 12)  return m_xb[i-8];
        else if (i == 12) return m_ctrl;
        return '0;
    endfunction

    task automatic model_write(int i, logic [63:0] d);
        if (i < 4)        m_wb[i]   = d;
        else if (i < 8)   m_wm[i-4] = d;
        else if (i < 12)  m_xb[i-8] = d;
        else if (i == 12) m_ctrl    = d;
    endtask

    task automatic check_outputs(string req);
        check(req, win_base_o,  {m_wb[3], m_wb[2], m_wb[1], m_wb[0]});
        check(req, win_mask_o,  {m_wm[3], m_wm[2], m_wm[1], m_wm[0]});
        check(req, xlat_base_o, {m_xb[3], m_xb[2], m_xb[1], m_xb[0]});
        check(req, ctrl_o, m_ctrl);
    endtask

    task automatic access(logic [31:0] a, logic wr, logic [1:0] sz, logic [63:0] d);
        bit          e = is_err(a, sz);
        logic [63:0] exp_rd;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_size = sz; req_wdata = d;
        exp_rd = (e || wr) ? 64'h0 : model_read(idx_of(a));
        if (wr && !e) model_write(idx_of(a), d);
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 rsp_valid", 256'(rsp_valid), 256'(1));
        check("R1 req_ready busy", 256'(req_ready), 256'(0));
        check("R3 R7 R2 rsp_err", 256'(rsp_err), 256'(e));
        check("R5 R6 R8 R9 rsp_rdata", 256'(rsp_rdata), 256'(exp_rd));
        check_outputs("R10 R8 R9 outputs");
        @(negedge clk);
        check("R1 rsp_valid single", 256'(rsp_valid), 256'(0));
    endtask

    function automatic logic [31:0] slot(int i, int lo);
        return BASE + 32'(i) * 32'd64 + 32'(lo);
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_bad++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        process::self().srandom(32'd1234);
        for (int i = 0; i < 4; i++) begin m_wb[i] = 0; m_wm[i] = 0; m_xb[i] = 0; end
        m_ctrl = 64'h0000_0021_0010_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 reset state visible at the outputs and through reads
        check_outputs("R4 reset outputs");
        check("R1 ready at idle", 256'(req_ready), 256'(1));
        access(slot(12, 0), 1'b0, 2'd3, 0);   // R4 control reads reset value
        access(slot(5, 0), 1'b0, 2'd3, 0);    // R4 mask reads zero
        // R5 round trip, R2 low address bits ignored
        access(slot(9, 0), 1'b1, 2'd3, 64'hDEAD_BEEF_0123_4567);
        access(slot(9, 37), 1'b0, 2'd3, 0);
        access(slot(12, 8), 1'b1, 2'd3, 64'hFFFF_0000_FFFF_0000);
        // R3 short sizes error, no change
        for (int s = 0; s < 3; s++) begin
            access(slot(1, 0), 1'b1, 2'(s), 64'h1111);
            access(slot(1, 0), 1'b0, 2'(s), 0);
        end
        // R6 invalidate-all slot
        access(slot(19, 0), 1'b1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        access(slot(19, 0), 1'b0, 2'd3, 0);
        // R7 unsupported and undecoded indices, R2 below base
        for (int i = 13; i < 23; i++) if (i != 19) access(slot(i, 0), 1'b1, 2'd3, 64'h55);
        access(BASE - 32'd64, 1'b1, 2'd3, 64'h77);
        access(BASE - 32'd1, 1'b0, 2'd3, 0);
        access(BASE + 32'h0010_0000, 1'b0, 2'd3, 0);
        // random mix
        for (int n = 0; n < 600; n++) begin
            int          i  = int'($urandom_range(0, 24));
            logic [1:0]  sz = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(0, 2)) : 2'd3;
            logic        wr = 1'($urandom_range(0, 1));
            logic [63:0] d  = {$urandom, $urandom};
            access(slot(i, int'($urandom_range(0, 63))), wr, sz, d);
        end
        // final read-back of every stored register
        for (int i = 0; i < 13; i++) access(slot(i, 0), 1'b0, 2'd3, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule